// File: doc/BRIEF.md
# MMU Access Permission Check and Fault Logging

This block sits after a page-table walk. It receives the final entry's 3-bit permission field, the modified bit and the translated physical address. It also receives the kind of access and the privilege level. In the same cycle it decides whether the access may proceed, which rights may be cached for the page, and which fault code applies. When an access is refused, the block records the reason and the page-aligned virtual address in two fault registers. A small read port exposes these registers, and reading the status register clears it.

A physical mode bypasses the check. In that mode, if boot redirection is enabled, instruction fetches are steered into a fixed boot memory window. All other physical accesses pass through unchanged with full rights. A no-fault mode lets user accesses that would fault proceed with full rights. Such accesses are still logged.

Top module: `perm_fault_unit`

## Requirements
- R1: The access index is {write, fetch, supervisor}, where `kind_i` bit 0 is write and bit 1 is fetch. A translated access needs read when it is neither a write nor a fetch, write when it is a write, and execute when it is a fetch. If any needed right is missing from the level's granted set, the fault code is 8 (protection); otherwise it is 0.
- R2: A user access to a page with permission field 6 or 7 gets fault code 12 (privilege), whatever the access kind.
- R3: `rights_o` uses bit 0 for read, bit 1 for write and bit 2 for execute. For permission fields 0 to 4 both levels get: R, RW, RX, RWX, X. For fields 5, 6 and 7, a supervisor gets RW, RX and RWX, while a user gets R, none and none.
- R4: The write bit of `rights_o` is cleared unless `modified_i` is set. This does not apply to a no-fault override.
- R5: When `nofault_i` is set, a user access with a nonzero code does not raise `fault_o`, and `rights_o` is RWX. The code is still reported and logged.
- R6: On a logged fault (valid, translated, nonzero code), the status register is first replaced by 1 if it was nonzero. Then (index << 5) | code | 2 is ORed into it. Bit 1 marks the address as valid and bit 0 marks overflow. Without a logged fault or a clear, both registers hold their values.
- R7: On a logged fault, the fault-address register takes `va_i` with its low 12 bits cleared.
- R8: In physical mode no fault is raised and the code is 0. When `boot_i` is set, a fetch (`kind_i` = 2) maps to BOOT_BASE OR va[18:0] with rights R and X only (3'b101). Any other physical access gives `pa_o` = `va_i` with rights 3'b111. In translated mode, `pa_o` = `pa_i`.
- R9: `reg_rdata_o` shows the status register when `reg_sel_i` = 0 and the address register when it is 1. A read with `reg_sel_i` = 0 clears the status register at the next edge. If a fault is logged in the same cycle, it is recorded as a fresh fault without overflow.
- R10: After reset, both fault registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A completed translation is presented |
| phys_i | input | 1 | Physical (untranslated) mode |
| boot_i | input | 1 | Boot redirection of fetches in physical mode |
| kind_i | input | 2 | Bit 0 write, bit 1 fetch |
| sup_i | input | 1 | Supervisor privilege |
| perm_i | input | 3 | Permission field of the final entry |
| modified_i | input | 1 | Page already marked modified |
| nofault_i | input | 1 | No-fault mode |
| va_i | input | VA_W | Virtual address |
| pa_i | input | VA_W | Physical address from the walk |
| rights_o | output | 3 | Granted rights {X, W, R} |
| fault_o | output | 1 | Access refused |
| fault_code_o | output | 4 | 0, 8 protection, 12 privilege |
| pa_o | output | VA_W | Resulting physical address |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 1 | 0 status, 1 address |
| reg_rdata_o | output | VA_W | Register read data |

## Verification
Random stimulus drives all 64 combinations of index and permission field under both settings of the modified bit and no-fault mode. This separates protection from privilege faults and separates table rights from the withheld write bit. Bursts of back-to-back faults with sparse reads show the overflow marking and the fresh record after a clear. They also show the clear racing a new fault in the same cycle. Physical-mode cycles with boot redirection on and off, using every access kind, confirm that only fetches are steered and trimmed to read and execute rights.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int RIGHTS_W = 3;
  localparam int CODE_W   = 4;
  localparam int IDX_W    = 3;
  localparam int FSR_W    = IDX_W + 5;
  localparam logic [RIGHTS_W-1:0] RT_R   = 3'b001;
  localparam logic [RIGHTS_W-1:0] RT_W   = 3'b010;
  localparam logic [RIGHTS_W-1:0] RT_X   = 3'b100;
  localparam logic [RIGHTS_W-1:0] RT_ALL = 3'b111;
  localparam logic [CODE_W-1:0] CODE_OK   = 4'd0;
  localparam logic [CODE_W-1:0] CODE_PROT = 4'd8;
  localparam logic [CODE_W-1:0] CODE_PRIV = 4'd12;
  typedef logic [RIGHTS_W-1:0] rights_t;
endpackage

// File: rtl/pfu_access_check.sv
module pfu_access_check
  import pfu_pkg::*;
(
  input  logic [1:0]        kind_i,
  input  logic              sup_i,
  input  logic [2:0]        perm_i,
  input  logic              modified_i,
  input  logic              nofault_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [CODE_W-1:0] code_o,
  output logic              override_o,
  output rights_t           rights_o
);
  rights_t lvl_rights, need;
  logic    is_wr, is_fe, priv_viol;

  assign is_wr = kind_i[0];
  assign is_fe = kind_i[1];
  assign idx_o = {is_wr, is_fe, sup_i};

  always_comb begin
    unique case (perm_i)
      3'd0: lvl_rights = RT_R;
      3'd1: lvl_rights = RT_R | RT_W;
      3'd2: lvl_rights = RT_R | RT_X;
      3'd3: lvl_rights = RT_ALL;
      3'd4: lvl_rights = RT_X;
      3'd5: lvl_rights = sup_i ? (RT_R | RT_W) : RT_R;
      3'd6: lvl_rights = sup_i ? (RT_R | RT_X) : '0;
      default: lvl_rights = sup_i ? RT_ALL : '0;
    endcase
  end

  always_comb begin
    need = '0;
    if (is_wr) need |= RT_W;
    if (is_fe) need |= RT_X;
    if (!is_wr && !is_fe) need |= RT_R;
  end

  assign priv_viol = !sup_i && (perm_i[2:1] == 2'b11);

  always_comb begin
    if (priv_viol)                    code_o = CODE_PRIV;
    else if ((need & ~lvl_rights) != '0) code_o = CODE_PROT;
    else                              code_o = CODE_OK;
  end

  // user faults are waved through in no-fault mode
  assign override_o = nofault_i && !sup_i && (code_o != CODE_OK);
  assign rights_o   = override_o ? RT_ALL
                                 : (lvl_rights & ~(modified_i ? '0 : RT_W));
endmodule

// File: rtl/pfu_boot_map.sv
module pfu_boot_map
  import pfu_pkg::*;
#(
  parameter int              VA_W      = 32,
  parameter int              BOOT_BITS = 19,
  parameter logic [VA_W-1:0] BOOT_BASE = 32'hFFD0_0000
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      kind_i,
  input  logic            boot_i,
  output logic [VA_W-1:0] pa_o,
  output rights_t         rights_o
);
  localparam int HI_W = VA_W - BOOT_BITS;
  logic redirect;

  assign redirect = boot_i && (kind_i == 2'b10);
  assign pa_o     = redirect ? (BOOT_BASE | {{HI_W{1'b0}}, va_i[BOOT_BITS-1:0]}) : va_i;
  assign rights_o = redirect ? (RT_R | RT_X) : RT_ALL;
endmodule

// File: rtl/pfu_fault_regs.sv
module pfu_fault_regs
  import pfu_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              log_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [VA_W-1:0]   va_i,
  output logic [FSR_W-1:0]  fsr_o,
  output logic [VA_W-1:0]   far_o
);
  logic [FSR_W-1:0] base, rec;

  assign base = clr_i ? '0 : fsr_o;

  always_comb begin
    rec = (base != '0) ? FSR_W'(1) : '0;
    rec = rec | {idx_i, 5'b0} | FSR_W'(code_i) | FSR_W'(2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_o <= '0;
      far_o <= '0;
    end else begin
      fsr_o <= log_i ? rec : base;
      if (log_i) far_o <= {va_i[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    end
  end
endmodule

// File: rtl/perm_fault_unit.sv
module perm_fault_unit
  import pfu_pkg::*;
#(
  parameter int              VA_W      = 32,
  parameter int              PAGE_BITS = 12,
  parameter int              BOOT_BITS = 19,
  parameter logic [VA_W-1:0] BOOT_BASE = 32'hFFD0_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            phys_i,
  input  logic            boot_i,
  input  logic [1:0]      kind_i,
  input  logic            sup_i,
  input  logic [2:0]      perm_i,
  input  logic            modified_i,
  input  logic            nofault_i,
  input  logic [VA_W-1:0] va_i,
  input  logic [VA_W-1:0] pa_i,
  output logic [2:0]      rights_o,
  output logic            fault_o,
  output logic [3:0]      fault_code_o,
  output logic [VA_W-1:0] pa_o,
  input  logic            reg_rd_i,
  input  logic            reg_sel_i,
  output logic [VA_W-1:0] reg_rdata_o
);
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] chk_code;
  logic              ovr, log_en, clr_en;
  rights_t           chk_rights, boot_rights;
  logic [VA_W-1:0]   boot_pa, far_q;
  logic [FSR_W-1:0]  fsr_q;

  pfu_access_check u_chk (
    .kind_i(kind_i), .sup_i(sup_i), .perm_i(perm_i), .modified_i(modified_i),
    .nofault_i(nofault_i), .idx_o(idx), .code_o(chk_code),
    .override_o(ovr), .rights_o(chk_rights)
  );

  pfu_boot_map #(.VA_W(VA_W), .BOOT_BITS(BOOT_BITS), .BOOT_BASE(BOOT_BASE)) u_boot (
    .va_i(va_i), .kind_i(kind_i), .boot_i(boot_i),
    .pa_o(boot_pa), .rights_o(boot_rights)
  );

  assign log_en = req_valid_i && !phys_i && (chk_code != CODE_OK);
  assign clr_en = reg_rd_i && !reg_sel_i;

  pfu_fault_regs #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .log_i(log_en), .clr_i(clr_en),
    .idx_i(idx), .code_i(chk_code), .va_i(va_i), .fsr_o(fsr_q), .far_o(far_q)
  );

  assign rights_o     = phys_i ? boot_rights : chk_rights;
  assign fault_code_o = phys_i ? CODE_OK : chk_code;
  assign fault_o      = log_en && !ovr;
  assign pa_o         = phys_i ? boot_pa : pa_i;
  assign reg_rdata_o  = reg_sel_i ? far_q : {{(VA_W-FSR_W){1'b0}}, fsr_q};
endmodule

// File: rtl/perm_fault_unit_chk.sv
module perm_fault_unit_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FSR_W     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             phys_i,
  input logic             boot_i,
  input logic [1:0]       kind_i,
  input logic             sup_i,
  input logic [2:0]       perm_i,
  input logic             modified_i,
  input logic             nofault_i,
  input logic             reg_rd_i,
  input logic             reg_sel_i,
  input logic [2:0]       rights_o,
  input logic             fault_o,
  input logic [3:0]       fault_code_o,
  input logic [FSR_W-1:0] fsr_q,
  input logic [VA_W-1:0]  far_q
);
  logic lg, clr;
  assign lg  = req_valid_i && !phys_i && (fault_code_o != 4'd0);
  assign clr = reg_rd_i && !reg_sel_i;

  AST_PRIV_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phys_i && !sup_i && perm_i[2:1] == 2'b11) |-> fault_code_o == 4'd12); // R2
  AST_WRITE_WITHHELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phys_i && !modified_i && !(nofault_i && !sup_i && fault_code_o != 4'd0)) |-> !rights_o[1]); // R4
  AST_NOFAULT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phys_i && nofault_i && !sup_i) |-> !fault_o); // R5
  AST_FAULT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lg |=> fsr_q[1]); // R6
  AST_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lg && fsr_q != '0 && !clr) |=> fsr_q[0]); // R6
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lg && !clr) |=> ($stable(fsr_q) && $stable(far_q))); // R6
  AST_FAR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lg |=> far_q[PAGE_BITS-1:0] == '0); // R7
  AST_BOOT_RIGHTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phys_i && boot_i && kind_i == 2'b10) |-> (rights_o == 3'b101 && !fault_o)); // R8
  AST_READ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !lg) |=> fsr_q == '0); // R9
endmodule

bind perm_fault_unit perm_fault_unit_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .FSR_W(pfu_pkg::FSR_W)) u_chk_bind (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .phys_i(phys_i),
  .boot_i(boot_i), .kind_i(kind_i), .sup_i(sup_i), .perm_i(perm_i),
  .modified_i(modified_i), .nofault_i(nofault_i), .reg_rd_i(reg_rd_i),
  .reg_sel_i(reg_sel_i), .rights_o(rights_o), .fault_o(fault_o),
  .fault_code_o(fault_code_o), .fsr_q(fsr_q), .far_q(far_q)
);

// File: tb/perm_fault_unit_tb_top.sv
`timescale 1ns/1ps
module perm_fault_unit_tb_top;
  localparam int VA_W = 32;
  localparam logic [31:0] BOOT_BASE = 32'hFFD0_0000;

  logic clk = 0, rst_ni = 0;
  logic req_valid, phys, boot, sup, modified, nofault, reg_rd, reg_sel;
  logic [1:0] kind;
  logic [2:0] perm;
  logic [31:0] va, pa;
  logic [2:0] rights;
  logic fault;
  logic [3:0] code;
  logic [31:0] pa_out, rdata;

  int tests = 0, fails = 0;
  int fsr_m = 0;
  logic [31:0] far_m = '0;

  // expected codes, row = {write,fetch,sup}, column = permission field
  int acc_tab [64] = '{0,0,0,0,8,0,12,12,  0,0,0,0,8,0,0,0,
                       8,8,0,0,0,8,12,12,  8,8,0,0,0,8,0,0,
                       8,0,8,0,8,8,12,12,  8,0,8,0,8,0,8,0,
                       8,8,8,0,8,8,12,12,  8,8,8,0,8,8,8,0};
  int rt_sup [8]  = '{1,3,5,7,4,3,5,7};
  int rt_user [8] = '{1,3,5,7,4,1,0,0};

  always #10 clk = ~clk;

  perm_fault_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .phys_i(phys),
    .boot_i(boot), .kind_i(kind), .sup_i(sup), .perm_i(perm),
    .modified_i(modified), .nofault_i(nofault), .va_i(va), .pa_i(pa),
    .rights_o(rights), .fault_o(fault), .fault_code_o(code), .pa_o(pa_out),
    .reg_rd_i(reg_rd), .reg_sel_i(reg_sel), .reg_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // check outputs mid-cycle, then advance model across the edge
  task automatic cycle();
    int idx, c, ur, nfsr;
    logic ovr, lg;
    logic [2:0] er;
    logic [31:0] epa;
    logic [31:0] nfar;
    #1;
    idx = {kind[0], kind[1], sup};
    if (phys) begin
      c = 0; ovr = 0;
      if (boot && kind == 2'b10) begin er = 3'b101; epa = BOOT_BASE | {13'b0, va[18:0]}; end
      else begin er = 3'b111; epa = va; end
    end else begin
      c = acc_tab[idx*8 + perm];
      ovr = (c != 0) && nofault && !sup;
      ur = sup ? rt_sup[perm] : rt_user[perm];
      er = ovr ? 3'b111 : (modified ? 3'(ur) : 3'(ur & 5));
      epa = pa;
    end
    lg = req_valid && !phys && c != 0;
    chk("R1 R2 code", {28'b0, code}, c);
    chk("R5 fault", {31'b0, fault}, {31'b0, lg && !ovr});
    chk("R3 R4 R5 R8 rights", {29'b0, rights}, {29'b0, er});
    chk("R8 pa", pa_out, epa);
    chk("R9 rdata", rdata, reg_sel ? far_m : fsr_m);
    nfsr = (reg_rd && !reg_sel) ? 0 : fsr_m;
    nfar = far_m;
    if (lg) begin
      nfsr = ((nfsr != 0) ? 1 : 0) | (idx << 5) | c | 2;   // R6
      nfar = {va[31:12], 12'b0};                            // R7
    end
    @(posedge clk);
    fsr_m = nfsr; far_m = nfar;
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic ph, input logic bt, input logic [1:0] k,
                       input logic s, input logic [2:0] p, input logic m, input logic nf,
                       input logic [31:0] a, input logic rd, input logic sel);
    req_valid = v; phys = ph; boot = bt; kind = k; sup = s; perm = p;
    modified = m; nofault = nf; va = a; pa = a ^ 32'h5A5A_0000; reg_rd = rd; reg_sel = sel;
    cycle();
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    drive(0,0,0,0,0,0,0,0,0,0,0);
    reg_sel = 0; #1; chk("R10 fsr reset", rdata, 0);
    reg_sel = 1; #1; chk("R10 far reset", rdata, 0);
    @(negedge clk); rst_ni = 1; @(negedge clk);
    // R2: user read of perm 6, then overflow on second fault (R6, R7)
    drive(1,0,0,2'b00,0,3'd6,1,0,32'h1234_5678,0,0);
    drive(1,0,0,2'b01,0,3'd0,1,0,32'hABCD_EFFF,0,1);
    // R9: read clear together with a fresh fault
    drive(1,0,0,2'b10,1,3'd1,0,0,32'h0000_1000,1,0);
    drive(0,0,0,2'b00,1,3'd0,0,0,32'h0,1,0);
    drive(0,0,0,2'b00,1,3'd0,0,0,32'h0,0,0);
    // R5: no-fault user write to read-only page
    drive(1,0,0,2'b01,0,3'd0,0,1,32'h7777_7000,0,1);
    // R8: boot fetch, boot read, boot off fetch
    drive(1,1,1,2'b10,0,3'd0,0,0,32'hDEAD_BEEF,0,0);
    drive(1,1,1,2'b00,0,3'd0,0,0,32'hDEAD_BEEF,0,0);
    drive(1,1,0,2'b10,0,3'd0,0,0,32'hDEAD_BEEF,0,0);
    // R4: supervisor write allowed but unmodified
    drive(1,0,0,2'b01,1,3'd3,0,0,32'h4000_0000,0,0);
    for (int i = 0; i < 4000; i++) begin
      drive($urandom%4 != 0, $urandom%8 == 0, $urandom%2, 2'($urandom), 1'($urandom),
            3'($urandom), 1'($urandom), $urandom%4 == 0, $urandom, $urandom%5 == 0, 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule